// File: doc/BRIEF.md
# Byte-Banked Transfer Length Counter

This block holds the transfer length for a storage controller's DMA path. Software programs a 24-bit count one byte at a time into three holding registers. The live counter is a separate set of three bytes that software reads back. The live counter takes the held value only when a command arrives with its DMA flag set. When the DMA engine reports completion, the live counter returns to zero and the terminal-count flag rises. Any later byte write lowers the flag again.

When a transfer starts, the block turns the live count into an effective length and registers it. A count of zero stands for 65536. The length is then limited by one of two bounds. In data mode the bound is the magnitude of the signed pending-data size. In command-collection mode the bound is the command buffer size.

The upper count byte has a second use. Until software writes it for the first time after a reset, reading it returns a fixed identification value.

Top module: `xfer_count_bank`

## Requirements
- R1: After reset, `tc`, `dma_mode` and `len_valid` are 0. Bytes 0 and 1 read back 0. Byte 2 reads back `CHIP_ID`.
- R2: A byte write (`wr_sel` 0 = bits 7:0, 1 = bits 15:8, 2 = bits 23:16) updates only the holding byte. The live byte read through `rd_sel` with the same encoding keeps its value until a reload. `rd_sel` 3 reads 0.
- R3: A byte write clears `tc` on the next cycle. If a completion arrives in the same cycle, `tc` is set instead.
- R4: `cmd_stb` with `cmd_dma` = 1 copies all three holding bytes into the live counter and sets `dma_mode`. `cmd_stb` with `cmd_dma` = 0 clears `dma_mode` and leaves the live counter unchanged.
- R5: Reading byte 2 returns `CHIP_ID` until byte 2 has been written once. After that it returns the live byte 2. A reset makes `CHIP_ID` visible again.
- R6: `done_stb` zeroes all live bytes and sets `tc`. It takes priority over a reload in the same cycle.
- R7: `len_valid` is high for exactly one cycle, the cycle after `ti_stb`. `eff_len` holds the computed length in that cycle.
- R8: A live count of 0 is treated as 65536 when the length is computed.
- R9: In data mode (`cmd_mode` = 0) the length is the smaller of the count and the magnitude of `pend_size`, which is two's complement. A negative size uses its magnitude.
- R10: In command-collection mode (`cmd_mode` = 1) the length is the smaller of the count and `CMDBUF_SZ`.
- R11: If `ti_stb` and a reload occur in the same cycle, the length is computed from the live count as it was before the reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 2 | Byte index to write |
| wr_data | input | 8 | Byte to write |
| cmd_stb | input | 1 | Command strobe |
| cmd_dma | input | 1 | DMA flag of the command |
| ti_stb | input | 1 | Transfer-start strobe |
| cmd_mode | input | 1 | 1 = command collection, 0 = data |
| pend_size | input | 25 | Signed pending data size |
| done_stb | input | 1 | DMA completion strobe |
| rd_sel | input | 2 | Byte index to read |
| rd_data | output | 8 | Readback byte |
| eff_len | output | 25 | Effective transfer length |
| len_valid | output | 1 | One-cycle qualifier for `eff_len` |
| tc | output | 1 | Terminal-count flag |
| dma_mode | output | 1 | Last command carried the DMA flag |

## Verification
Three pairs of functions can coincide in one clock edge:

- A byte write and a completion both drive `tc`.
- A reload and a completion both drive the live bytes.
- A transfer start and a reload both involve the live count.

The bench raises each pair of strobes together in a single cycle. It then judges the outcome at the ports. It reads `tc` and the live bytes through `rd_sel`, and it compares `eff_len` against the count that was live before the edge.

// File: rtl/xcb_pkg.sv
package xcb_pkg;
  typedef enum logic [1:0] {
    BYTE_LO  = 2'd0,
    BYTE_MID = 2'd1,
    BYTE_HI  = 2'd2,
    BYTE_NONE = 2'd3
  } byte_sel_e;

  // smaller of two unsigned values
  function automatic logic [31:0] lesser(input logic [31:0] a, input logic [31:0] b);
    lesser = (a < b) ? a : b;
  endfunction

  // count of zero stands for a full 64K transfer
  function automatic logic [31:0] span_of(input logic [31:0] cnt);
    span_of = (cnt == 32'd0) ? 32'h0001_0000 : cnt;
  endfunction
endpackage

// File: rtl/xcb_byte_reg.sv
module xcb_byte_reg #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              reload,
  input  logic              clear,
  output logic [BYTE_W-1:0] shadow,
  output logic [BYTE_W-1:0] live
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
      live   <= '0;
    end else begin
      if (wr) shadow <= wdata;
      if (clear)       live <= '0;
      else if (reload) live <= shadow;
    end
  end
endmodule

// File: rtl/xcb_len_calc.sv
module xcb_len_calc #(
  parameter int COUNT_W    = 24,
  parameter int CMDBUF_SZ  = 32,
  localparam int LEN_W     = COUNT_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    cmd_mode,
  input  logic [COUNT_W-1:0]      count,
  input  logic signed [LEN_W-1:0] pend,
  output logic [LEN_W-1:0]        len,
  output logic                    valid
);
  import xcb_pkg::*;

  function automatic logic [LEN_W-1:0] magnitude(input logic signed [LEN_W-1:0] v);
    magnitude = v[LEN_W-1] ? LEN_W'(-v) : LEN_W'(v);
  endfunction

  logic [31:0]      span_w;
  logic [31:0]      bound_w;
  logic [LEN_W-1:0] len_next;

  always_comb begin
    span_w   = span_of(32'(count));
    bound_w  = cmd_mode ? 32'(CMDBUF_SZ) : 32'(magnitude(pend));
    len_next = LEN_W'(lesser(span_w, bound_w));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len   <= '0;
      valid <= 1'b0;
    end else begin
      valid <= start;
      if (start) len <= len_next;
    end
  end
endmodule

// File: rtl/xfer_count_bank.sv
module xfer_count_bank #(
  parameter int          BYTE_W    = 8,
  parameter int          NBYTES    = 3,
  parameter int          CMDBUF_SZ = 32,
  parameter logic [7:0]  CHIP_ID   = 8'h5A,
  localparam int         COUNT_W   = BYTE_W * NBYTES,
  localparam int         LEN_W     = COUNT_W + 1,
  localparam int         SEL_W     = (NBYTES > 1) ? $clog2(NBYTES + 1) : 1,
  localparam int         HI_IDX    = NBYTES - 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [SEL_W-1:0]        wr_sel,
  input  logic [BYTE_W-1:0]       wr_data,
  input  logic                    cmd_stb,
  input  logic                    cmd_dma,
  input  logic                    ti_stb,
  input  logic                    cmd_mode,
  input  logic signed [LEN_W-1:0] pend_size,
  input  logic                    done_stb,
  input  logic [SEL_W-1:0]        rd_sel,
  output logic [BYTE_W-1:0]       rd_data,
  output logic [LEN_W-1:0]        eff_len,
  output logic                    len_valid,
  output logic                    tc,
  output logic                    dma_mode
);
  // named internal events
  logic               reload_ev;
  logic               hi_write_ev;
  logic               hi_written;
  logic [COUNT_W-1:0] live_count;
  logic [COUNT_W-1:0] shadow_count;
  logic [BYTE_W-1:0]  live_b   [NBYTES];
  logic [BYTE_W-1:0]  shadow_b [NBYTES];

  assign reload_ev   = cmd_stb && cmd_dma;
  assign hi_write_ev = wr_en && (wr_sel == SEL_W'(HI_IDX));

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    logic wr_hit;
    assign wr_hit = wr_en && (wr_sel == SEL_W'(i));
    xcb_byte_reg #(.BYTE_W(BYTE_W)) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (wr_hit),
      .wdata  (wr_data),
      .reload (reload_ev),
      .clear  (done_stb),
      .shadow (shadow_b[i]),
      .live   (live_b[i])
    );
    assign live_count[i*BYTE_W +: BYTE_W]   = live_b[i];
    assign shadow_count[i*BYTE_W +: BYTE_W] = shadow_b[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tc         <= 1'b0;
      dma_mode   <= 1'b0;
      hi_written <= 1'b0;
    end else begin
      if (done_stb)   tc <= 1'b1;
      else if (wr_en) tc <= 1'b0;
      if (cmd_stb) dma_mode <= cmd_dma;
      if (hi_write_ev) hi_written <= 1'b1;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NBYTES; k++) begin
      if (rd_sel == SEL_W'(k)) rd_data = live_b[k];
    end
    if ((rd_sel == SEL_W'(HI_IDX)) && !hi_written) rd_data = BYTE_W'(CHIP_ID);
  end

  xcb_len_calc #(.COUNT_W(COUNT_W), .CMDBUF_SZ(CMDBUF_SZ)) u_len (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (ti_stb),
    .cmd_mode (cmd_mode),
    .count    (live_count),
    .pend     (pend_size),
    .len      (eff_len),
    .valid    (len_valid)
  );
endmodule

// File: rtl/xcb_chk.sv
module xcb_chk #(
  parameter int COUNT_W = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               cmd_stb,
  input logic               cmd_dma,
  input logic               ti_stb,
  input logic               done_stb,
  input logic               tc,
  input logic               dma_mode,
  input logic               len_valid,
  input logic               hi_written,
  input logic [COUNT_W-1:0] live_count,
  input logic [COUNT_W-1:0] shadow_count
);
  // R7
  valid_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ti_stb |=> len_valid);
  // R7
  valid_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ti_stb |=> !len_valid);
  // R6
  done_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_stb |=> (tc && live_count == '0));
  // R3
  write_clears_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !done_stb) |=> !tc);
  // R4
  reload_copies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && cmd_dma && !done_stb) |=> (live_count == $past(shadow_count)));
  // R4
  plain_cmd_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && !cmd_dma) |=> !dma_mode);
  // R5
  id_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_written |=> hi_written);
endmodule

bind xfer_count_bank xcb_chk #(.COUNT_W(COUNT_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .cmd_stb      (cmd_stb),
  .cmd_dma      (cmd_dma),
  .ti_stb       (ti_stb),
  .done_stb     (done_stb),
  .tc           (tc),
  .dma_mode     (dma_mode),
  .len_valid    (len_valid),
  .hi_written   (hi_written),
  .live_count   (live_count),
  .shadow_count (shadow_count)
);

// File: tb/xfer_count_bank_test.sv
`timescale 1ns/1ps
module xfer_count_bank_test;
  localparam logic [7:0] ID = 8'h5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [7:0]  wr_data = 8'd0;
  logic        cmd_stb = 1'b0;
  logic        cmd_dma = 1'b0;
  logic        ti_stb = 1'b0;
  logic        cmd_mode = 1'b0;
  logic signed [24:0] pend_size = '0;
  logic        done_stb = 1'b0;
  logic [1:0]  rd_sel = 2'd0;
  logic [7:0]  rd_data;
  logic [24:0] eff_len;
  logic        len_valid;
  logic        tc;
  logic        dma_mode;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  xfer_count_bank uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cmd_stb(cmd_stb), .cmd_dma(cmd_dma), .ti_stb(ti_stb), .cmd_mode(cmd_mode),
    .pend_size(pend_size), .done_stb(done_stb), .rd_sel(rd_sel), .rd_data(rd_data),
    .eff_len(eff_len), .len_valid(len_valid), .tc(tc), .dma_mode(dma_mode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // advance one clock; inputs set before are captured, pulses dropped after
  task automatic step();
    @(negedge clk);
    wr_en = 0; cmd_stb = 0; cmd_dma = 0; ti_stb = 0; done_stb = 0;
  endtask

  task automatic read_byte(input logic [1:0] s, output logic [7:0] v);
    rd_sel = s;
    #0.5;
    v = rd_data;
  endtask

  task automatic wr_byte(input logic [1:0] s, input logic [7:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    step();
  endtask

  task automatic load_count(input logic [23:0] c);
    wr_byte(2'd0, c[7:0]);
    wr_byte(2'd1, c[15:8]);
    wr_byte(2'd2, c[23:16]);
    cmd_stb = 1; cmd_dma = 1;
    step();
  endtask

  task automatic start_len(input logic cm, input logic signed [24:0] p);
    cmd_mode = cm; pend_size = p; ti_stb = 1;
    step();
  endtask

  task automatic do_reset();
    rst_n = 0;
    step(); step();
    rst_n = 1;
    step();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 tc", 32'(tc), 0);
    chk("R1 dma_mode", 32'(dma_mode), 0);
    chk("R1 len_valid", 32'(len_valid), 0);
    read_byte(2'd0, v); chk("R1 byte0", 32'(v), 0);
    read_byte(2'd1, v); chk("R1 byte1", 32'(v), 0);
    read_byte(2'd2, v); chk("R1 R5 byte2 id", 32'(v), 32'(ID));
  endtask

  task automatic t_shadow_only();
    logic [7:0] v;
    wr_byte(2'd0, 8'h34);
    read_byte(2'd0, v); chk("R2 live lo unchanged", 32'(v), 0);
    read_byte(2'd2, v); chk("R5 id before hi write", 32'(v), 32'(ID));
    wr_byte(2'd1, 8'h12);
    wr_byte(2'd2, 8'h00);
    read_byte(2'd2, v); chk("R5 hi after write", 32'(v), 0);
    read_byte(2'd3, v); chk("R2 sel3 zero", 32'(v), 0);
  endtask

  task automatic t_reload();
    logic [7:0] v;
    cmd_stb = 1; cmd_dma = 1; step();
    read_byte(2'd0, v); chk("R4 lo reload", 32'(v), 32'h34);
    read_byte(2'd1, v); chk("R4 mid reload", 32'(v), 32'h12);
    chk("R4 dma_mode set", 32'(dma_mode), 1);
    wr_byte(2'd0, 8'h77);
    cmd_stb = 1; cmd_dma = 0; step();
    chk("R4 dma_mode clr", 32'(dma_mode), 0);
    read_byte(2'd0, v); chk("R4 no reload", 32'(v), 32'h34);
  endtask

  task automatic t_len_data();
    load_count(24'h001234);
    start_len(0, 25'sd256);
    chk("R7 valid", 32'(len_valid), 1);
    chk("R9 pos bound", 32'(eff_len), 32'h100);
    step();
    chk("R7 one pulse", 32'(len_valid), 0);
    start_len(0, -25'sd8192);
    chk("R9 neg bound", 32'(eff_len), 32'h1234);
    load_count(24'h030000);
    start_len(0, 25'sh0100000);
    chk("R9 count smaller", 32'(eff_len), 32'h30000);
  endtask

  task automatic t_len_cmd();
    load_count(24'h001234);
    start_len(1, 25'sd5);
    chk("R10 cmdbuf bound", 32'(eff_len), 32);
    load_count(24'h000010);
    start_len(1, 25'sd5);
    chk("R10 count bound", 32'(eff_len), 16);
  endtask

  task automatic t_zero();
    load_count(24'h000000);
    start_len(0, 25'sh0020000);
    chk("R8 zero is 64K", 32'(eff_len), 32'h10000);
    start_len(1, 25'sd0);
    chk("R8 R10 zero cmd", 32'(eff_len), 32);
  endtask

  task automatic t_done();
    logic [7:0] v;
    load_count(24'h0A0B0C);
    done_stb = 1; step();
    chk("R6 tc set", 32'(tc), 1);
    read_byte(2'd0, v); chk("R6 lo zero", 32'(v), 0);
    read_byte(2'd2, v); chk("R6 hi zero", 32'(v), 0);
    wr_byte(2'd1, 8'h55);
    chk("R3 write clears tc", 32'(tc), 0);
    wr_en = 1; wr_sel = 2'd0; wr_data = 8'h01; done_stb = 1; step();
    chk("R3 done wins tc", 32'(tc), 1);
    cmd_stb = 1; cmd_dma = 1; done_stb = 1; step();
    read_byte(2'd1, v); chk("R6 done beats reload", 32'(v), 0);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    load_count(24'h000040);
    wr_byte(2'd0, 8'h08);
    cmd_stb = 1; cmd_dma = 1;
    cmd_mode = 0; pend_size = 25'sh0100000; ti_stb = 1;
    step();
    chk("R11 old count used", 32'(eff_len), 32'h40);
    read_byte(2'd0, v); chk("R11 reload taken", 32'(v), 32'h08);
  endtask

  task automatic t_reset_id();
    logic [7:0] v;
    do_reset();
    read_byte(2'd2, v); chk("R5 id after reset", 32'(v), 32'(ID));
    chk("R1 tc after reset", 32'(tc), 0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_shadow_only();
    t_reload();
    t_len_data();
    t_len_cmd();
    t_zero();
    t_done();
    t_collide();
    t_reset_id();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end
endmodule